// File: doc/BRIEF.md
# Complementary PWM Dead-Time Inserter

This block turns each incoming PWM waveform into a pair of gate drives: a true drive that follows the waveform and a complement drive that follows its inverse. Each drive may rise only after a programmable non-overlap delay. This keeps the two external switches of a half bridge from ever conducting together. A falling edge on either drive takes effect at once. Only rising edges are delayed.

The two rising-edge delays are set separately but share one clock divider. The divider can slow the delay counters by 1, 2, 4 or 8. Several channels are handled in parallel with the same settings. A group of fault inputs stops every drive at once. The stop does not wait for a clock edge. It then stays in force until a clear is issued while no fault is present.

Top module: `dti_top`

## Requirements
- R1: While rst_n is low, every drv_hi and drv_lo bit is 0.
- R2: The delay for drv_hi is taken from dt_delays[7:4]. When pwm_in of a channel is first sampled high at clock edge k, drv_lo of that channel is 0 after edge k. drv_hi rises after edge k + dt_delays[7:4] × F, where F is the division factor.
- R3: The delay for drv_lo is taken from dt_delays[3:0]. When pwm_in is first sampled low at edge k, drv_hi is 0 after edge k. drv_lo rises after edge k + dt_delays[3:0] × F.
- R4: dt_div_sel values 0, 1, 2 and 3 give F = 1, 2, 4 and 8.
- R5: A delay field of 0 makes that drive rise after the very edge that samples the new pwm_in level.
- R6: drv_hi and drv_lo of a channel are never both 1.
- R7: If pwm_in returns to its former level before a pending delay has expired, that rising edge is dropped. Both drives of the channel remain 0 until the opposite delay expires.
- R8: Any fault_in bit at 1 (active-high default) forces all drives to 0 at once, without waiting for a clock edge.
- R9: A fault is latched. The drives stay 0 after fault_in returns low, until fault_clr is 1 at a clock edge where no fault_in bit is 1. Fault_clr has no effect while a fault is present. After a clear, each delay is counted afresh, starting at the following edge.
- R10: Channels operate independently on their own pwm_in bits under the shared delay and divider settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | NUM_CH | PWM waveform per channel |
| dt_div_sel | input | SEL_W | Delay counter division select |
| dt_delays | input | 2*FIELD_W | Upper field: true-drive delay; lower field: complement-drive delay |
| fault_in | input | NUM_FAULT | Fault sources, OR-combined |
| fault_clr | input | 1 | Clears the latched fault when no fault is present |
| drv_hi | output | NUM_CH | True (high-side) drive per channel |
| drv_lo | output | NUM_CH | Complement (low-side) drive per channel |

## Verification
The bench builds the block with NUM_CH = 3, FIELD_W = 4, SEL_W = 2 and NUM_FAULT = 2, all active high. Three channels with unrelated waveforms expose any coupling between lanes. The two-bit select reaches every division factor up to 8, so the longest delay is 120 cycles. Two fault sources allow a clear to be attempted while the second source is still held.

// File: rtl/dti_pkg.sv
package dti_pkg;
   localparam int DEF_FIELD_W = 4;
   localparam int DEF_SEL_W   = 2;

   typedef enum logic {
      FLT_ACT_HIGH = 1'b0,
      FLT_ACT_LOW  = 1'b1
   } flt_pol_e;
endpackage

// File: rtl/dti_prescale.sv
// Restartable divider: tick every 2**sel cycles while run is high.
module dti_prescale #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   generate
      if (SEL_W == 0) begin : g_nodiv
         assign tick = run;
      end else begin : g_div
         localparam int PRE_W = (1 << SEL_W) - 1;
         logic [PRE_W-1:0] pre_q;
         logic [PRE_W-1:0] limit;

         assign limit = (PRE_W'(1) << sel) - PRE_W'(1);
         assign tick  = run && (pre_q == limit);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          pre_q <= '0;
            else if (!run||tick) pre_q <= '0;
            else                 pre_q <= pre_q + PRE_W'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/dti_edge_delay.sv
// Delays the rising edge of one drive; falling edges pass on the same edge.
module dti_edge_delay #(
   parameter int FIELD_W = 4,
   parameter int SEL_W   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               want,
   input  logic               kill,
   input  logic [FIELD_W-1:0] field,
   input  logic [SEL_W-1:0]   sel,
   output logic               drive
);
   logic [FIELD_W-1:0] cnt_q;
   logic               out_q;
   logic               reached;
   logic               counting;
   logic               tick;

   assign reached  = (cnt_q >= field);
   assign counting = want && !kill && !out_q && !reached;

   dti_prescale #(.SEL_W(SEL_W)) presc_i (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (counting),
      .sel   (sel),
      .tick  (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         out_q <= 1'b0;
      end else if (kill || !want) begin
         cnt_q <= '0;
         out_q <= 1'b0;
      end else if (!out_q && reached) begin
         out_q <= 1'b1;
      end else if (tick) begin
         cnt_q <= cnt_q + FIELD_W'(1);
      end
   end

   assign drive = out_q;
endmodule

// File: rtl/dti_fault_latch.sv
// Combines fault sources; live view plus a sticky copy cleared on request.
module dti_fault_latch import dti_pkg::*; #(
   parameter int       NUM_SRC = 2,
   parameter flt_pol_e POL     = FLT_ACT_HIGH
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src,
   input  logic               clr,
   output logic               live,
   output logic               held
);
   generate
      if (POL == FLT_ACT_LOW) begin : g_low
         assign live = ~&src;
      end else begin : g_high
         assign live = |src;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    held <= 1'b0;
      else if (live) held <= 1'b1;
      else if (clr)  held <= 1'b0;
   end
endmodule

// File: rtl/dti_top.sv
module dti_top import dti_pkg::*; #(
   parameter int       NUM_CH    = 3,
   parameter int       FIELD_W   = DEF_FIELD_W,
   parameter int       SEL_W     = DEF_SEL_W,
   parameter int       NUM_FAULT = 2,
   parameter flt_pol_e FAULT_POL = FLT_ACT_HIGH
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_CH-1:0]      pwm_in,
   input  logic [SEL_W-1:0]       dt_div_sel,
   input  logic [2*FIELD_W-1:0]   dt_delays,
   input  logic [NUM_FAULT-1:0]   fault_in,
   input  logic                   fault_clr,
   output logic [NUM_CH-1:0]      drv_hi,
   output logic [NUM_CH-1:0]      drv_lo
);
   localparam int DT_W = 2 * FIELD_W;

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("dti_top: NUM_CH must be at least 1");
      end
      if (FIELD_W < 1 || FIELD_W > 8) begin : g_bad_fw
         $error("dti_top: FIELD_W must be 1..8");
      end
      if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
         $error("dti_top: SEL_W must be 1..3");
      end
      if (NUM_FAULT < 1) begin : g_bad_flt
         $error("dti_top: NUM_FAULT must be at least 1");
      end
   endgenerate

   logic [FIELD_W-1:0] rise_hi_field;
   logic [FIELD_W-1:0] rise_lo_field;
   logic               flt_live;
   logic               flt_held;
   logic               block;

   assign rise_hi_field = dt_delays[DT_W-1:FIELD_W];
   assign rise_lo_field = dt_delays[FIELD_W-1:0];

   dti_fault_latch #(.NUM_SRC(NUM_FAULT), .POL(FAULT_POL)) flt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (fault_in),
      .clr   (fault_clr),
      .live  (flt_live),
      .held  (flt_held)
   );

   assign block = flt_live | flt_held;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic hi_q;
         logic lo_q;

         dti_edge_delay #(.FIELD_W(FIELD_W), .SEL_W(SEL_W)) hi_i (
            .clk   (clk),
            .rst_n (rst_n),
            .want  (pwm_in[c]),
            .kill  (block),
            .field (rise_hi_field),
            .sel   (dt_div_sel),
            .drive (hi_q)
         );

         dti_edge_delay #(.FIELD_W(FIELD_W), .SEL_W(SEL_W)) lo_i (
            .clk   (clk),
            .rst_n (rst_n),
            .want  (~pwm_in[c]),
            .kill  (block),
            .field (rise_lo_field),
            .sel   (dt_div_sel),
            .drive (lo_q)
         );

         assign drv_hi[c] = hi_q & ~block;
         assign drv_lo[c] = lo_q & ~block;
      end
   endgenerate
endmodule

// File: rtl/dti_chk.sv
module dti_chk import dti_pkg::*; #(
   parameter int       NUM_CH    = 3,
   parameter int       NUM_FAULT = 2,
   parameter flt_pol_e FAULT_POL = FLT_ACT_HIGH
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_CH-1:0]    pwm_in,
   input logic [NUM_FAULT-1:0] fault_in,
   input logic [NUM_CH-1:0]    drv_hi,
   input logic [NUM_CH-1:0]    drv_lo
);
   logic fault_any;
   generate
      if (FAULT_POL == FLT_ACT_LOW) begin : g_low
         assign fault_any = ~&fault_in;
      end else begin : g_high
         assign fault_any = |fault_in;
      end
   endgenerate

   a_r8_fault_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
      fault_any |-> ((drv_hi | drv_lo) == '0));

   a_r9_fault_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fault_any) |-> ((drv_hi | drv_lo) == '0));

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
            !(drv_hi[c] && drv_lo[c]));

         a_r2_hi_rise_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(drv_hi[c]) |-> $past(pwm_in[c]));

         a_r2_hi_drops_with_low: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!pwm_in[c]) |-> !drv_hi[c]);

         a_r3_lo_rise_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(drv_lo[c]) |-> !$past(pwm_in[c]));

         a_r3_lo_drops_with_high: assert property (@(posedge clk) disable iff (!rst_n)
            $past(pwm_in[c]) |-> !drv_lo[c]);
      end
   endgenerate
endmodule

bind dti_top dti_chk #(
   .NUM_CH    (NUM_CH),
   .NUM_FAULT (NUM_FAULT),
   .FAULT_POL (FAULT_POL)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .pwm_in   (pwm_in),
   .fault_in (fault_in),
   .drv_hi   (drv_hi),
   .drv_lo   (drv_lo)
);

// File: tb/dti_top_tb_top.sv
module dti_top_tb_top;
   localparam int NUM_CH = 3;
   localparam int WD_CYC = 20000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NUM_CH-1:0] pwm_in = '0;
   logic [1:0]        dt_div_sel = 2'd0;
   logic [7:0]        dt_delays = 8'h00;
   logic [1:0]        fault_in = 2'b00;
   logic              fault_clr = 1'b0;
   logic [NUM_CH-1:0] drv_hi;
   logic [NUM_CH-1:0] drv_lo;

   int    checks = 0;
   int    fails  = 0;
   string cur_tag = "R1";

   typedef struct {
      logic [NUM_CH-1:0] hi;
      logic [NUM_CH-1:0] lo;
      string             tag;
   } exp_t;
   exp_t sb_q[$];

   int runh[NUM_CH];
   int runl[NUM_CH];
   bit lat = 1'b0;

   always #4 clk = ~clk;

   dti_top #(.NUM_CH(NUM_CH), .FIELD_W(4), .SEL_W(2), .NUM_FAULT(2)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwm_in     (pwm_in),
      .dt_div_sel (dt_div_sel),
      .dt_delays  (dt_delays),
      .fault_in   (fault_in),
      .fault_clr  (fault_clr),
      .drv_hi     (drv_hi),
      .drv_lo     (drv_lo)
   );

   // Reference from the requirements, evaluated at each rising edge.
   task automatic predict();
      exp_t e;
      int   dh = int'(dt_delays[7:4]) << dt_div_sel;
      int   dl = int'(dt_delays[3:0]) << dt_div_sel;
      bit   anyf = |fault_in;
      bit   kill = anyf | lat;
      e.tag = cur_tag;
      if (!rst_n) begin
         lat = 1'b0;
         for (int c = 0; c < NUM_CH; c++) begin
            runh[c] = 0;
            runl[c] = 0;
         end
         e.hi = '0;
         e.lo = '0;
      end else begin
         lat = anyf ? 1'b1 : (fault_clr ? 1'b0 : lat);
         for (int c = 0; c < NUM_CH; c++) begin
            if (kill || !pwm_in[c]) runh[c] = 0;
            else if (runh[c] < 1000) runh[c]++;
            if (kill || pwm_in[c]) runl[c] = 0;
            else if (runl[c] < 1000) runl[c]++;
            e.hi[c] = !(anyf | lat) && (runh[c] > dh);
            e.lo[c] = !(anyf | lat) && (runl[c] > dl);
         end
      end
      sb_q.push_back(e);
   endtask

   task automatic drive(input logic [NUM_CH-1:0] v, input int n);
      for (int i = 0; i < n; i++) begin
         pwm_in = v;
         @(posedge clk);
         predict();
         @(negedge clk);
      end
   endtask

   // Monitor: pops one expected item per edge and compares.
   always begin
      exp_t e;
      @(posedge clk);
      #2;
      checks++;
      if (sb_q.size() == 0) begin
         fails++;
         $display("FAIL %s scoreboard empty actual=none expected=item", cur_tag);
      end else begin
         e = sb_q.pop_front();
         if (drv_hi !== e.hi || drv_lo !== e.lo) begin
            fails++;
            $display("FAIL %s scoreboard at %0t: hi actual=%b expected=%b, lo actual=%b expected=%b",
                     e.tag, $time, drv_hi, e.hi, drv_lo, e.lo);
         end
      end
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic reconfig(input logic [1:0] sel, input logic [7:0] dly);
      cur_tag = "R9";
      fault_in[1] = 1'b1;
      drive(pwm_in, 2);
      dt_div_sel = sel;
      dt_delays  = dly;
      fault_in[1] = 1'b0;
      drive(pwm_in, 1);
      fault_clr = 1'b1;
      drive(pwm_in, 1);
      fault_clr = 1'b0;
   endtask

   // Returns edges until the chosen drive of channel 0 rises.
   task automatic measure(input bit lo_side, input logic [NUM_CH-1:0] v, output int n);
      bit seen = 1'b0;
      n = 0;
      for (int i = 0; i < 200 && !seen; i++) begin
         drive(v, 1);
         n++;
         seen = lo_side ? drv_lo[0] : drv_hi[0];
      end
   endtask

   initial begin
      int n;
      int hi_seen;
      // R1: reset
      cur_tag = "R1";
      drive('0, 4);
      check((drv_hi | drv_lo) == '0, "R1", "drives during reset", int'(drv_hi | drv_lo), 0);
      rst_n = 1'b1;

      // R5: zero delay
      cur_tag = "R5";
      drive(3'b000, 3);
      drive(3'b101, 1);
      check(drv_hi == 3'b101, "R5", "hi right after edge", int'(drv_hi), 5);
      check(drv_lo == 3'b010, "R5", "lo right after edge", int'(drv_lo), 2);
      drive(3'b010, 2);
      drive(3'b111, 1);
      drive(3'b000, 2);

      // R2 R3 R10: independent waveforms, delays 5 and 3
      reconfig(2'd0, 8'h53);
      cur_tag = "R10";
      for (int i = 0; i < 60; i++)
         drive({(i >= 30), ((i % 14) < 5), ((i % 20) < 10)}, 1);
      cur_tag = "R2";
      drive(3'b000, 8);
      measure(1'b0, 3'b001, n);
      check(n == 6, "R2", "edges to hi rise, field 5", n, 6);
      check(drv_lo[1] && drv_lo[2], "R10", "other lanes keep lo", int'(drv_lo), 6);
      cur_tag = "R3";
      drive(3'b001, 8);
      measure(1'b1, 3'b000, n);
      check(n == 4, "R3", "edges to lo rise, field 3", n, 4);

      // R4: division factors
      for (int s = 1; s < 4; s++) begin
         reconfig(2'(s), 8'h21);
         cur_tag = "R4";
         drive(3'b000, 20);
         measure(1'b0, 3'b111, n);
         check(n == (2 << s) + 1, "R4", "hi rise edges", n, (2 << s) + 1);
         drive(3'b111, 20);
         measure(1'b1, 3'b000, n);
         check(n == (1 << s) + 1, "R4", "lo rise edges", n, (1 << s) + 1);
      end

      // R7: short pulses cancel
      reconfig(2'd1, 8'h44);
      cur_tag = "R7";
      drive(3'b000, 12);
      hi_seen = 0;
      for (int i = 0; i < 3; i++) begin
         drive(3'b111, 1);
         hi_seen |= int'(drv_hi);
      end
      drive(3'b000, 3);
      hi_seen |= int'(drv_hi);
      check(drv_lo == '0, "R7", "lo still waiting", int'(drv_lo), 0);
      for (int i = 0; i < 5; i++) begin
         drive(3'b111, 1);
         hi_seen |= int'(drv_hi);
      end
      check(hi_seen == 0, "R7", "hi during short pulses", hi_seen, 0);
      drive(3'b000, 20);
      check(drv_lo == 3'b111, "R7", "lo after long low", int'(drv_lo), 7);

      // R8 R9: fault shutdown and latch
      reconfig(2'd0, 8'h11);
      cur_tag = "R8";
      drive(3'b101, 6);
      check(drv_hi == 3'b101, "R8", "hi before fault", int'(drv_hi), 5);
      fault_in = 2'b01;
      #1;
      check((drv_hi | drv_lo) == '0, "R8", "drives before next edge", int'(drv_hi | drv_lo), 0);
      drive(3'b101, 3);
      cur_tag = "R9";
      fault_in = 2'b00;
      drive(3'b101, 4);
      check((drv_hi | drv_lo) == '0, "R9", "drives after fault released", int'(drv_hi | drv_lo), 0);
      fault_in = 2'b10;
      fault_clr = 1'b1;
      drive(3'b101, 2);
      fault_in = 2'b00;
      fault_clr = 1'b0;
      drive(3'b101, 2);
      check((drv_hi | drv_lo) == '0, "R9", "clear during fault ignored", int'(drv_hi | drv_lo), 0);
      fault_clr = 1'b1;
      drive(3'b101, 1);
      fault_clr = 1'b0;
      drive(3'b101, 1);
      check(drv_hi == '0, "R9", "delay restarts after clear", int'(drv_hi), 0);
      drive(3'b101, 4);
      check(drv_hi == 3'b101, "R9", "hi resumes", int'(drv_hi), 5);
      check(drv_lo == 3'b010, "R9", "lo resumes", int'(drv_lo), 2);
      drive(3'b000, 3);

      #1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(WD_CYC * 8);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule